// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Decimal Correction

This block is the arithmetic core of a small accumulator machine. Each clock it takes the accumulator, a second operand byte, the B register, the carry and auxiliary-carry flags and a five-bit operation select. One cycle later it presents the new accumulator, new B and new second-operand values, plus carry, auxiliary-carry and overflow flags. Every result comes with its own write enable, so the surrounding datapath writes back only what the operation changes.

The operations cover binary add and subtract with carry-in and borrow, increment and decrement, bitwise logic, clear and complement, nibble swap, and rotates with and without the carry. It also has a low-nibble exchange with the second operand, an unsigned multiply into the B:A pair, an unsigned divide giving a quotient and a remainder, and a decimal correction step that follows a packed-BCD addition. Operand fetch, the register file and instruction sequencing sit outside the block.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, every value and every write enable output is zero on the next cycle.
- R2: Results appear on the outputs one clock after the inputs are presented. The select codes are: 0 add, 1 add with carry, 2 subtract with borrow, 3 increment, 4 decrement, 5 AND, 6 OR, 7 XOR, 8 clear, 9 complement, 10 nibble swap, 11 rotate left, 12 rotate left through carry, 13 rotate right, 14 rotate right through carry, 15 low-nibble exchange, 16 multiply, 17 divide, 18 decimal correction. Codes 19 to 31 raise no write enable.
- R3: Add (code 0) gives A+X. Add with carry (code 1) gives A+X+C. Both write carry (carry out of bit 7), auxiliary carry (carry out of bit 3) and overflow (signed two's-complement overflow).
- R4: Subtract with borrow (code 2) gives A−X−C. It writes carry as the borrow out of bit 7, auxiliary carry as the borrow out of bit 3, and overflow as signed overflow.
- R5: Increment and decrement wrap modulo 256 and write only the accumulator.
- R6: AND, OR, XOR, clear (result 0x00) and complement (bitwise inverse) write only the accumulator.
- R7: Swap exchanges the two nibbles of A. Plain rotate left moves bit 7 into bit 0, and plain rotate right moves bit 0 into bit 7. None of them writes a flag.
- R8: Rotate left through carry moves bit 7 to carry and the old carry to bit 0. Rotate right through carry moves bit 0 to carry and the old carry to bit 7. Carry is the only flag these write.
- R9: Low-nibble exchange returns A with its bits 3..0 taken from X, and X with its bits 3..0 taken from A. It writes both of them and no flag.
- R10: Multiply writes the 16-bit product A×B with the high byte to B and the low byte to A. It clears carry, and sets overflow exactly when the high byte is non-zero.
- R11: Divide with B non-zero writes the quotient to A and the remainder to B, and clears both carry and overflow.
- R12: Divide with B zero sets overflow and clears carry. It does not write A or B.
- R13: Decimal correction adds 0x06 when the low nibble exceeds 9 or AC is set. It then adds 0x60 when the high nibble of that intermediate exceeds 9, when that step carried, or when C is set. It writes A and carry. The new carry is the old C ORed with the carry of either step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation select |
| acc_i | input | 8 | Accumulator |
| opnd_i | input | 8 | Second operand |
| b_i | input | 8 | B register |
| cy_i | input | 1 | Carry flag |
| ac_i | input | 1 | Auxiliary carry flag |
| acc_o | output | 8 | New accumulator |
| acc_we | output | 1 | Accumulator write enable |
| b_o | output | 8 | New B register |
| b_we | output | 1 | B write enable |
| opnd_o | output | 8 | New second operand |
| opnd_we | output | 1 | Second operand write enable |
| cy_o | output | 1 | New carry |
| cy_we | output | 1 | Carry write enable |
| ac_o | output | 1 | New auxiliary carry |
| ac_we | output | 1 | Auxiliary carry write enable |
| ov_o | output | 1 | New overflow |
| ov_we | output | 1 | Overflow write enable |

## Verification
The only state in the block is its single output register, so a wrong internal value shows at the ports exactly one cycle after the operation that caused it. A fault confined to one datapath shows up only for the select codes routed through it: a bad nibble carry shows as a wrong auxiliary carry or a wrong decimal correction, and a bad divider shows as a quotient and remainder that do not rebuild the dividend. A wrong enable shows as a flag or register written by an operation that must leave it alone. That cannot be seen from the values, which is why every enable is compared on every cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_INC  = 5'd3,
    OP_DEC  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_CLR  = 5'd8,
    OP_CPL  = 5'd9,
    OP_SWAP = 5'd10,
    OP_RL   = 5'd11,
    OP_RLC  = 5'd12,
    OP_RR   = 5'd13,
    OP_RRC  = 5'd14,
    OP_XCHD = 5'd15,
    OP_MUL  = 5'd16,
    OP_DIV  = 5'd17,
    OP_DA   = 5'd18
  } alu_op_e;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   x,
  input  logic           cy,
  output logic [W-1:0]   res,
  output logic           cy_o,
  output logic           ac_o,
  output logic           ov_o
);
  localparam int H = W / 2;

  logic         cin;
  logic [W:0]   full;
  logic [H:0]   lo;

  always_comb begin
    cin  = (op == OP_ADDC || op == OP_SUBB) ? cy : 1'b0;
    full = '0;
    lo   = '0;
    ov_o = 1'b0;
    if (op == OP_SUBB) begin
      full = {1'b0, a} - {1'b0, x} - {{W{1'b0}}, cin};
      lo   = {1'b0, a[H-1:0]} - {1'b0, x[H-1:0]} - {{H{1'b0}}, cin};
      ov_o = (a[W-1] != x[W-1]) && (full[W-1] != a[W-1]);
    end else begin
      full = {1'b0, a} + {1'b0, x} + {{W{1'b0}}, cin};
      lo   = {1'b0, a[H-1:0]} + {1'b0, x[H-1:0]} + {{H{1'b0}}, cin};
      ov_o = (a[W-1] == x[W-1]) && (full[W-1] != a[W-1]);
    end
    cy_o = full[W];
    ac_o = lo[H];
    case (op)
      OP_INC:  res = a + W'(1);
      OP_DEC:  res = a - W'(1);
      default: res = full[W-1:0];
    endcase
  end
endmodule

// File: rtl/acc_alu_shlog.sv
module acc_alu_shlog
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   x,
  input  logic           cy,
  output logic [W-1:0]   res,
  output logic [W-1:0]   xres,
  output logic           cy_o
);
  localparam int H = W / 2;

  always_comb begin
    res  = a;
    xres = x;
    cy_o = cy;
    case (op)
      OP_AND:  res = a & x;
      OP_OR:   res = a | x;
      OP_XOR:  res = a ^ x;
      OP_CLR:  res = '0;
      OP_CPL:  res = ~a;
      OP_SWAP: res = {a[H-1:0], a[W-1:H]};
      OP_RL:   res = {a[W-2:0], a[W-1]};
      OP_RR:   res = {a[0], a[W-1:1]};
      OP_RLC: begin
        res  = {a[W-2:0], cy};
        cy_o = a[W-1];
      end
      OP_RRC: begin
        res  = {cy, a[W-1:1]};
        cy_o = a[0];
      end
      OP_XCHD: begin
        res  = {a[W-1:H], x[H-1:0]};
        xres = {x[W-1:H], a[H-1:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         dz
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod    = (2*W)'(a) * (2*W)'(b);
    prod_lo = prod[W-1:0];
    prod_hi = prod[2*W-1:W];
    dz      = (b == '0);
    quo     = dz ? '0 : a / b;
    rem     = dz ? '0 : a % b;
  end
endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cy,
  input  logic         ac,
  output logic [W-1:0] res,
  output logic         cy_o
);
  localparam int H = W / 2;

  logic       lo_fix, hi_fix;
  logic [W:0] t, u;

  always_comb begin
    lo_fix = (a[H-1:0] > H'(9)) || ac;
    t      = {1'b0, a} + (lo_fix ? (W+1)'(6) : '0);
    hi_fix = t[W] || cy || (t[W-1:H] > H'(9));
    u      = {1'b0, t[W-1:0]} + (hi_fix ? (W+1)'(6 << H) : '0);
    res    = u[W-1:0];
    cy_o   = cy | t[W] | u[W];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   opnd_i,
  input  logic [W-1:0]   b_i,
  input  logic           cy_i,
  input  logic           ac_i,
  output logic [W-1:0]   acc_o,
  output logic           acc_we,
  output logic [W-1:0]   b_o,
  output logic           b_we,
  output logic [W-1:0]   opnd_o,
  output logic           opnd_we,
  output logic           cy_o,
  output logic           cy_we,
  output logic           ac_o,
  output logic           ac_we,
  output logic           ov_o,
  output logic           ov_we
);
  logic [W-1:0] ar_res, lg_res, lg_x, p_lo, p_hi, q, r, da_res;
  logic         ar_cy, ar_ac, ar_ov, lg_cy, dz, da_cy;

  acc_alu_arith #(.W(W)) u_arith (
    .op(op_i), .a(acc_i), .x(opnd_i), .cy(cy_i),
    .res(ar_res), .cy_o(ar_cy), .ac_o(ar_ac), .ov_o(ar_ov)
  );

  acc_alu_shlog #(.W(W)) u_shlog (
    .op(op_i), .a(acc_i), .x(opnd_i), .cy(cy_i),
    .res(lg_res), .xres(lg_x), .cy_o(lg_cy)
  );

  acc_alu_muldiv #(.W(W)) u_muldiv (
    .a(acc_i), .b(b_i),
    .prod_lo(p_lo), .prod_hi(p_hi), .quo(q), .rem(r), .dz(dz)
  );

  acc_alu_bcd #(.W(W)) u_bcd (
    .a(acc_i), .cy(cy_i), .ac(ac_i), .res(da_res), .cy_o(da_cy)
  );

  logic [W-1:0] acc_n, b_n, x_n;
  logic         cy_n, ac_n, ov_n;
  logic         acc_e, b_e, x_e, cy_e, ac_e, ov_e;

  always_comb begin
    acc_n = acc_i; b_n = b_i; x_n = opnd_i;
    cy_n  = cy_i;  ac_n = ac_i; ov_n = 1'b0;
    acc_e = 1'b0; b_e = 1'b0; x_e = 1'b0;
    cy_e  = 1'b0; ac_e = 1'b0; ov_e = 1'b0;
    case (op_i)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        acc_n = ar_res; cy_n = ar_cy; ac_n = ar_ac; ov_n = ar_ov;
        acc_e = 1'b1; cy_e = 1'b1; ac_e = 1'b1; ov_e = 1'b1;
      end
      OP_INC, OP_DEC: begin
        acc_n = ar_res; acc_e = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL, OP_SWAP, OP_RL, OP_RR: begin
        acc_n = lg_res; acc_e = 1'b1;
      end
      OP_RLC, OP_RRC: begin
        acc_n = lg_res; cy_n = lg_cy; acc_e = 1'b1; cy_e = 1'b1;
      end
      OP_XCHD: begin
        acc_n = lg_res; x_n = lg_x; acc_e = 1'b1; x_e = 1'b1;
      end
      OP_MUL: begin
        acc_n = p_lo; b_n = p_hi; cy_n = 1'b0; ov_n = (p_hi != '0);
        acc_e = 1'b1; b_e = 1'b1; cy_e = 1'b1; ov_e = 1'b1;
      end
      OP_DIV: begin
        cy_n = 1'b0; cy_e = 1'b1; ov_e = 1'b1; ov_n = dz;
        if (!dz) begin
          acc_n = q; b_n = r; acc_e = 1'b1; b_e = 1'b1;
        end
      end
      OP_DA: begin
        acc_n = da_res; cy_n = da_cy; acc_e = 1'b1; cy_e = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0; b_o <= '0; opnd_o <= '0;
      cy_o <= 1'b0; ac_o <= 1'b0; ov_o <= 1'b0;
      acc_we <= 1'b0; b_we <= 1'b0; opnd_we <= 1'b0;
      cy_we <= 1'b0; ac_we <= 1'b0; ov_we <= 1'b0;
    end else begin
      acc_o <= acc_n; b_o <= b_n; opnd_o <= x_n;
      cy_o <= cy_n; ac_o <= ac_n; ov_o <= ov_n;
      acc_we <= acc_e; b_we <= b_e; opnd_we <= x_e;
      cy_we <= cy_e; ac_we <= ac_e; ov_we <= ov_e;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> !(acc_we || b_we || opnd_we || cy_we || ac_we || ov_we));

  assert_unused_code_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) > OP_DA)
      |-> !(acc_we || b_we || opnd_we || cy_we || ac_we || ov_we));

  assert_add_sum_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_ADD)
      |-> ({cy_o, acc_o} == {1'b0, $past(acc_i)} + {1'b0, $past(opnd_i)}));

  assert_logic_no_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_AND || $past(op_i) == OP_OR ||
                     $past(op_i) == OP_XOR))
      |-> (acc_we && !cy_we && !ac_we && !ov_we));

  assert_xchd_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_XCHD)
      |-> (acc_o[W-1:W/2] == $past(acc_i[W-1:W/2]) &&
           opnd_o[W/2-1:0] == $past(acc_i[W/2-1:0]) && opnd_we));

  assert_mul_pair_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_MUL)
      |-> ({b_o, acc_o} == (2*W)'($past(acc_i)) * (2*W)'($past(b_i)) &&
           !cy_o && ov_o == (b_o != '0)));

  assert_div_rebuild_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_DIV && $past(b_i) != '0)
      |-> ((2*W)'(acc_o) * (2*W)'($past(b_i)) + (2*W)'(b_o) == (2*W)'($past(acc_i)) &&
           b_o < $past(b_i) && !ov_o));

  assert_div_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_DIV && $past(b_i) == '0)
      |-> (ov_o && ov_we && !cy_o && !acc_we && !b_we));
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb_top;
  import acc_alu_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0, b_i = '0;
  logic       cy_i = 1'b0, ac_i = 1'b0;
  logic [7:0] acc_o, b_o, opnd_o;
  logic       acc_we, b_we, opnd_we, cy_o, cy_we, ac_o, ac_we, ov_o, ov_we;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .b_i(b_i), .cy_i(cy_i), .ac_i(ac_i),
    .acc_o(acc_o), .acc_we(acc_we), .b_o(b_o), .b_we(b_we),
    .opnd_o(opnd_o), .opnd_we(opnd_we), .cy_o(cy_o), .cy_we(cy_we),
    .ac_o(ac_o), .ac_we(ac_we), .ov_o(ov_o), .ov_we(ov_we)
  );

  function automatic string req_of(input logic [4:0] op);
    case (op)
      0, 1:               return "R3";
      2:                  return "R4";
      3, 4:               return "R5";
      5, 6, 7, 8, 9:      return "R6";
      10, 11, 13:         return "R7";
      12, 14:             return "R8";
      15:                 return "R9";
      16:                 return "R10";
      17:                 return (b_i == 0) ? "R12" : "R11";
      18:                 return "R13";
      default:            return "R2";
    endcase
  endfunction

  // Reference model: returns {we[5:0], acc, b, x, cy, ac, ov}
  task automatic model(input logic [4:0] op, input logic [7:0] a, x, b,
                       input logic c, h,
                       output logic [7:0] ea, eb, ex, output logic ec, eh, eo,
                       output logic [5:0] we);
    int t, s, l;
    ea = a; eb = b; ex = x; ec = c; eh = h; eo = 1'b0; we = '0;
    case (op)
      0, 1: begin
        t = int'(a) + int'(x) + ((op == 1) ? int'(c) : 0);
        l = int'(a & 8'hF) + int'(x & 8'hF) + ((op == 1) ? int'(c) : 0);
        s = int'($signed(a)) + int'($signed(x)) + ((op == 1) ? int'(c) : 0);
        ea = t[7:0]; ec = (t > 255); eh = (l > 15); eo = (s > 127 || s < -128);
        we = 6'b100111;
      end
      2: begin
        t = int'(a) - int'(x) - int'(c);
        l = int'(a & 8'hF) - int'(x & 8'hF) - int'(c);
        s = int'($signed(a)) - int'($signed(x)) - int'(c);
        ea = t[7:0]; ec = (t < 0); eh = (l < 0); eo = (s > 127 || s < -128);
        we = 6'b100111;
      end
      3: begin ea = a + 8'd1; we = 6'b100000; end
      4: begin ea = a - 8'd1; we = 6'b100000; end
      5: begin ea = a & x; we = 6'b100000; end
      6: begin ea = a | x; we = 6'b100000; end
      7: begin ea = a ^ x; we = 6'b100000; end
      8: begin ea = 8'h00; we = 6'b100000; end
      9: begin ea = ~a; we = 6'b100000; end
      10: begin ea = {a[3:0], a[7:4]}; we = 6'b100000; end
      11: begin ea = {a[6:0], a[7]}; we = 6'b100000; end
      12: begin ea = {a[6:0], c}; ec = a[7]; we = 6'b100100; end
      13: begin ea = {a[0], a[7:1]}; we = 6'b100000; end
      14: begin ea = {c, a[7:1]}; ec = a[0]; we = 6'b100100; end
      15: begin ea = {a[7:4], x[3:0]}; ex = {x[7:4], a[3:0]}; we = 6'b101000; end
      16: begin
        t = int'(a) * int'(b);
        ea = t[7:0]; eb = t[15:8]; ec = 1'b0; eo = (t > 255); we = 6'b110101;
      end
      17: begin
        ec = 1'b0;
        if (b == 0) begin eo = 1'b1; we = 6'b000101; end
        else begin
          ea = 8'(int'(a) / int'(b)); eb = 8'(int'(a) % int'(b)); eo = 1'b0;
          we = 6'b110101;
        end
      end
      18: begin
        t = int'(a);
        if ((t % 16) > 9 || h) t = t + 6;
        if (t > 255 || c || ((t % 256) / 16) > 9) begin
          ec = 1'b1; t = (t % 256) + 96;
        end
        if (t > 255) ec = 1'b1;
        ea = t[7:0]; we = 6'b100100;
      end
      default: ;
    endcase
  endtask

  task automatic apply(input logic [4:0] op, input logic [7:0] a, x, b,
                       input logic c, h);
    logic [7:0] ea, eb, ex;
    logic ec, eh, eo;
    logic [5:0] we, got;
    string rq;
    op_i = op; acc_i = a; opnd_i = x; b_i = b; cy_i = c; ac_i = h;
    model(op, a, x, b, c, h, ea, eb, ex, ec, eh, eo, we);
    rq = req_of(op);
    @(negedge clk);
    got = {acc_we, b_we, opnd_we, cy_we, ac_we, ov_we};
    checks++;
    if (got !== we ||
        (we[5] && acc_o !== ea) || (we[4] && b_o !== eb) ||
        (we[3] && opnd_o !== ex) || (we[2] && cy_o !== ec) ||
        (we[1] && ac_o !== eh) || (we[0] && ov_o !== eo)) begin
      errs++;
      $display("FAIL %s op=%0d a=%h x=%h b=%h c=%b h=%b: got we=%b acc=%h b=%h x=%h cy=%b ac=%b ov=%b exp we=%b acc=%h b=%h x=%h cy=%b ac=%b ov=%b",
               rq, op, a, x, b, c, h, got, acc_o, b_o, opnd_o, cy_o, ac_o, ov_o,
               we, ea, eb, ex, ec, eh, eo);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    op_i = 5'd16; acc_i = 8'hFF; b_i = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero under reset
    checks++;
    if ({acc_o, b_o, opnd_o, cy_o, ac_o, ov_o, acc_we, b_we, opnd_we,
         cy_we, ac_we, ov_we} !== '0) begin
      errs++;
      $display("FAIL R1 reset outputs acc=%h b=%h we=%b exp all zero", acc_o, b_o,
               {acc_we, b_we, opnd_we, cy_we, ac_we, ov_we});
    end
    rst = 1'b0;

    // Directed corner cases
    apply(5'd0, 8'h7F, 8'h01, 8'h00, 1'b0, 1'b0);  // R3 signed overflow, AC
    apply(5'd1, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0);  // R3 carry-in wraps
    apply(5'd2, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0);  // R4 borrow
    apply(5'd2, 8'h80, 8'h00, 8'h00, 1'b1, 1'b0);  // R4 signed overflow
    apply(5'd3, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1);  // R5 wrap
    apply(5'd4, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);  // R5 wrap
    apply(5'd8, 8'hA5, 8'h00, 8'h00, 1'b1, 1'b1);  // R6 clear
    apply(5'd10, 8'h3C, 8'h00, 8'h00, 1'b0, 1'b0); // R7 swap
    apply(5'd12, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0); // R8 carry out
    apply(5'd14, 8'h01, 8'h00, 8'h00, 1'b1, 1'b0); // R8 carry in
    apply(5'd15, 8'h12, 8'h34, 8'h00, 1'b0, 1'b0); // R9
    apply(5'd16, 8'hFF, 8'h00, 8'hFF, 1'b1, 1'b0); // R10 large product
    apply(5'd16, 8'h0F, 8'h00, 8'h11, 1'b1, 1'b0); // R10 fits one byte
    apply(5'd17, 8'hFB, 8'h00, 8'h12, 1'b1, 1'b0); // R11
    apply(5'd17, 8'h55, 8'h00, 8'h00, 1'b1, 1'b0); // R12
    apply(5'd18, 8'hBD, 8'h00, 8'h00, 1'b0, 1'b0); // R13 0x56+0x67 -> 0x23, C
    apply(5'd18, 8'h9A, 8'h00, 8'h00, 1'b0, 1'b0); // R13 both steps
    apply(5'd18, 8'h42, 8'h00, 8'h00, 1'b0, 1'b1); // R13 AC only
    apply(5'd25, 8'h11, 8'h22, 8'h33, 1'b1, 1'b1); // R2 unused code
    apply(5'd31, 8'h11, 8'h22, 8'h33, 1'b0, 1'b0); // R2 unused code

    // Constrained random: mostly defined codes, some unused, some zero divisors
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] op;
      logic [7:0] b;
      op = ($urandom % 8 == 0) ? 5'($urandom) : 5'($urandom % 19);
      b  = ($urandom % 16 == 0) ? 8'h00 : 8'($urandom);
      apply(op, 8'($urandom), 8'($urandom), b, 1'($urandom), 1'($urandom));
    end

    // R1: reset asserted mid-run clears everything again
    op_i = 5'd0; acc_i = 8'hFF; opnd_i = 8'hFF; rst = 1'b1;
    @(negedge clk);
    checks++;
    if ({acc_we, b_we, opnd_we, cy_we, ac_we, ov_we, acc_o} !== '0) begin
      errs++;
      $display("FAIL R1 mid-run reset we=%b acc=%h exp zero",
               {acc_we, b_we, opnd_we, cy_we, ac_we, ov_we}, acc_o);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule